// File: doc/BRIEF.md
# Serializer with Loopback Select

This block converts 10-bit parallel words into a serial bit stream, least significant bit first. It runs on a fast system clock and advances one bit on each cycle where a bit-rate enable is high. That enable is expected to pulse ten times per word period. The block samples the next word on the bit slot that follows the last bit of the current word, so words leave back to back with no idle slot. A one-cycle `word_take` strobe tells the upstream source when its word is being sampled.

A single loopback control selects the route. In normal mode the serial stream drives the line output, and the receive-side select passes the line input through to the receiver. In wrap mode the line output is frozen at logic 0. The stream then goes to an internal loopback port, and the receive-side select takes that port in place of the line input. This allows a transmit-to-receive test without the transmission medium.

Top module: `ser_loop_tx`

## Requirements
- R1: A synchronous active-high reset clears the shifter, so `line_out`, `wrap_out` and the serial stream are 0. They stay 0 until the first word is taken. The first cycle with `bit_en` high after reset takes `word_in`.
- R2: `word_take` is high only in a cycle where `bit_en` is high and the word is being sampled. Once running, that happens on exactly one of every ten `bit_en` cycles.
- R3: The clock edge that takes a word puts its bit 0 on the serial stream. After k more `bit_en` edges the stream carries bit k of that word, for k from 1 to 9.
- R4: The `bit_en` slot that directly follows bit 9 of a word takes the next word. No slot is left idle between words.
- R5: The serial stream and the shift state change only on edges where `bit_en` is high.
- R6: With `loop_en` = 0, `line_out` carries the serial stream, `wrap_out` is 0 and `rx_bit` equals `line_in`.
- R7: With `loop_en` = 1, `line_out` is held at 0 and does not toggle.
- R8: With `loop_en` = 1, `wrap_out` carries the serial stream and `rx_bit` equals `wrap_out`. `line_in` has no effect on `rx_bit`.
- R9: Changing `loop_en` does not disturb word timing. A word taken in the same cycle as a route change is sent complete and in order on the new route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable, ten pulses per word period |
| word_in | input | 10 | Parallel word to send, bit 0 goes first |
| word_take | output | 1 | High in the cycle where `word_in` is sampled |
| loop_en | input | 1 | 0 = line route, 1 = wrap (internal loopback) route |
| line_in | input | 1 | Serial data from the line |
| line_out | output | 1 | Serial data to the line, 0 in wrap mode |
| wrap_out | output | 1 | Internal loopback stream, 0 in normal mode |
| rx_bit | output | 1 | Receive-side select output: `line_in` or the loopback stream |

## Verification
Two events can fall in the same cycle: a word load at a word boundary and a change of route. The bench provokes this by watching for a pending `word_take` and flipping `loop_en` on the falling edge just before the load edge. It then rebuilds the new word from `wrap_out`, LSB first, and compares it with the word sampled at that edge. On every cycle of the run, a bench-side model of the stream is also compared with `line_out`, `wrap_out` and `rx_bit`. This confirms that the line froze on the switch cycle and the loopback port picked up bit 0 with no gap.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic {
        ROUTE_LINE = 1'b0,
        ROUTE_WRAP = 1'b1
    } route_e;

    typedef struct packed {
        logic line;
        logic wrap;
        logic rx;
    } route_out_t;

    function automatic route_e route_of(input logic loop_ctl);
        return loop_ctl ? ROUTE_WRAP : ROUTE_LINE;
    endfunction

    function automatic route_out_t steer(input route_e r, input logic stream, input logic line_rx);
        route_out_t o;
        o.line = (r == ROUTE_LINE) ? stream : 1'b0;
        o.wrap = (r == ROUTE_WRAP) ? stream : 1'b0;
        o.rx   = (r == ROUTE_WRAP) ? o.wrap : line_rx;
        return o;
    endfunction

endpackage

// File: rtl/ser_frame_ctl.sv
module ser_frame_ctl #(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    output logic take,
    output logic started
);
    localparam int SLOT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_W - 1);

    logic [SLOT_W-1:0] slot;

    assign take = bit_en && (!started || (slot == LAST_SLOT));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= '0;
            started <= 1'b0;
        end else if (bit_en) begin
            if (take) begin
                slot    <= '0;
                started <= 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    // R2: two loads never fall on neighbouring cycles
    p_take_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    // R1: once running, the block never returns to the idle state without reset
    p_stays_started_r1: assert property (@(posedge clk) disable iff (rst)
        started |=> started);

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              take,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_bit
);
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (take) begin
            shreg <= word_in;
        end else if (bit_en) begin
            shreg <= shreg >> 1;
        end
    end

    assign ser_bit = shreg[0];

    // R5: without an enable the shift state holds
    p_hold_without_en_r5: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(shreg));

endmodule

// File: rtl/ser_route.sv
module ser_route
    import ser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic loop_en,
    input  logic ser_bit,
    input  logic line_in,
    output logic line_out,
    output logic wrap_out,
    output logic rx_bit
);
    route_out_t ro;

    always_comb begin
        ro = steer(route_of(loop_en), ser_bit, line_in);
    end

    assign line_out = ro.line;
    assign wrap_out = ro.wrap;
    assign rx_bit   = ro.rx;

    // R7: the line does not toggle while wrapped
    p_line_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (loop_en && $past(loop_en)) |-> $stable(line_out));

    // R8: the receive side sees the transmit stream in wrap mode
    p_rx_wrapped_r8: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (rx_bit == ser_bit));

    // R6: the loopback port is quiet in normal mode
    p_wrap_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !loop_en |-> !wrap_out);

endmodule

// File: rtl/ser_loop_tx.sv
module ser_loop_tx #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_take,
    input  logic              loop_en,
    input  logic              line_in,
    output logic              line_out,
    output logic              wrap_out,
    output logic              rx_bit
);
    logic take;
    logic started;
    logic ser_bit;

    ser_frame_ctl #(.WORD_W(WORD_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .take    (take),
        .started (started)
    );

    ser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .take    (take),
        .word_in (word_in),
        .ser_bit (ser_bit)
    );

    ser_route u_route (
        .clk      (clk),
        .rst      (rst),
        .loop_en  (loop_en),
        .ser_bit  (ser_bit),
        .line_in  (line_in),
        .line_out (line_out),
        .wrap_out (wrap_out),
        .rx_bit   (rx_bit)
    );

    assign word_take = take;

    // R1: nothing is shifted out before the first word
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !started |-> !ser_bit);

    // R3: the load edge presents bit 0 of the sampled word
    p_lsb_first_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(take) && !$past(rst)) |-> (ser_bit == $past(word_in[0])));

    // R5: the stream holds between enables
    p_stream_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(ser_bit));

endmodule

// File: tb/ser_loop_tx_tb.sv
`timescale 1ns/1ps
module ser_loop_tx_tb;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic loop_en = 1'b0;
    logic line_in = 1'b0;
    logic [W-1:0] word_in = '0;
    logic word_take, line_out, wrap_out, rx_bit;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    int  div    = 3;
    int  cnt    = 0;
    int  idx    = 0;
    int  seed   = 0;
    bit  gen_on = 1'b0;
    bit  mon_on = 1'b0;

    logic [W-1:0] m_sh   = '0;
    logic [W-1:0] m_last = '0;
    int  m_slot   = 0;
    bit  m_st     = 1'b0;
    bit  m_loaded = 1'b0;
    bit  m_adv    = 1'b0;

    always #4 clk = ~clk;

    ser_loop_tx #(.WORD_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .word_in   (word_in),
        .word_take (word_take),
        .loop_en   (loop_en),
        .line_in   (line_in),
        .line_out  (line_out),
        .wrap_out  (wrap_out),
        .rx_bit    (rx_bit)
    );

    function automatic logic [W-1:0] pat(input int i, input int s);
        int v;
        v = (i * 37 + s * 113 + 5) ^ (i << 3);
        if (i % 5 == 3) v = 1023;
        if (i % 7 == 4) v = 0;
        return v[W-1:0];
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chkw(input logic [W-1:0] act, input logic [W-1:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // stimulus: bit enable and word source
    always @(negedge clk) begin
        if (gen_on) begin
            bit_en <= (cnt == 0);
            cnt    <= (cnt + 1 >= div) ? 0 : cnt + 1;
        end else begin
            bit_en <= 1'b0;
            cnt    <= 0;
        end
        word_in <= pat(idx, seed);
    end

    // bench model of the stream and per-cycle comparison
    always @(posedge clk) begin
        logic e;
        bit   took;
        took     = (bit_en === 1'b1) && (!m_st || m_slot == W - 1);
        m_loaded = 1'b0;
        m_adv    = 1'b0;
        if (rst) begin
            m_sh = '0; m_slot = 0; m_st = 1'b0; idx = 0;
        end else if (bit_en === 1'b1) begin
            m_adv = 1'b1;
            if (took) begin
                m_sh = word_in; m_last = word_in; m_slot = 0; m_st = 1'b1; m_loaded = 1'b1;
                idx++;
            end else begin
                m_sh = m_sh >> 1; m_slot++;
            end
        end
        #1;
        if (mon_on) begin
            e = m_sh[0];
            chk(line_out, loop_en ? 1'b0 : e, loop_en ? "R7" : "R6", "line_out");
            chk(wrap_out, loop_en ? e : 1'b0, loop_en ? "R8" : "R6", "wrap_out");
            chk(rx_bit, loop_en ? e : line_in, loop_en ? "R8" : "R6", "rx_bit");
            chk(word_take, (bit_en === 1'b1) && (!m_st || m_slot == W - 1), "R2", "word_take");
        end
    end

    task automatic step;
        @(posedge clk); #2;
    endtask

    // rebuild one word LSB first from a chosen output; check the next slot reloads
    task automatic get_word(input bit use_wrap, output logic [W-1:0] got, output logic [W-1:0] exp_w);
        do step(); while (!m_loaded);
        exp_w  = m_last;
        got    = '0;
        got[0] = use_wrap ? wrap_out : line_out;
        for (int k = 1; k < W; k++) begin
            do step(); while (!m_adv);
            got[k] = use_wrap ? wrap_out : line_out;
        end
        while (bit_en !== 1'b1) step();
        chk(word_take, 1'b1, "R4", "reload in slot after bit 9");
    endtask

    task automatic t_reset;
        gen_on = 1'b0; loop_en = 1'b0; line_in = 1'b0;
        rst = 1'b1;
        repeat (3) step();
        chk(line_out, 1'b0, "R1", "line_out in reset");
        chk(wrap_out, 1'b0, "R1", "wrap_out in reset");
        chk(rx_bit, 1'b0, "R1", "rx_bit in reset");
        @(negedge clk); rst = 1'b0;
        mon_on = 1'b1;
        repeat (6) begin
            step();
            chk(line_out, 1'b0, "R1", "idle before first word");
            chk(word_take, 1'b0, "R1", "no take without enable");
        end
    endtask

    task automatic t_first_word;
        logic [W-1:0] g, x;
        @(negedge clk); gen_on = 1'b1;
        get_word(1'b0, g, x);
        chkw(x, pat(0, seed), "R1", "first word taken after reset");
        chkw(g, x, "R3", "first word LSB first");
    endtask

    task automatic t_normal(input int d);
        logic [W-1:0] g, x;
        div = d;
        loop_en = 1'b0;
        for (int n = 0; n < 4; n++) begin
            get_word(1'b0, g, x);
            chkw(g, x, "R3", "line word");
        end
    endtask

    task automatic t_hold;
        logic prev;
        div = 4;
        repeat (8) step();
        for (int n = 0; n < 40; n++) begin
            prev = line_out;
            step();
            if (!m_adv) chk(line_out, prev, "R5", "stable without enable");
        end
    endtask

    task automatic t_wrap;
        logic [W-1:0] g, x;
        bit toggled;
        div = 2;
        @(negedge clk); loop_en = 1'b1;
        toggled = 1'b0;
        fork
            begin
                repeat (120) begin
                    @(negedge clk); line_in = ~line_in;
                end
            end
            begin
                for (int n = 0; n < 3; n++) begin
                    get_word(1'b1, g, x);
                    chkw(g, x, "R8", "wrap word");
                end
            end
            begin
                repeat (100) begin
                    step();
                    if (line_out !== 1'b0) toggled = 1'b1;
                end
            end
        join
        chk(toggled, 1'b0, "R7", "line_out frozen in wrap");
    endtask

    task automatic t_rx_normal;
        @(negedge clk); loop_en = 1'b0;
        for (int n = 0; n < 12; n++) begin
            @(negedge clk); line_in = n[0] ^ n[2];
            #1;
            chk(rx_bit, line_in, "R6", "rx follows line_in");
            chk(wrap_out, 1'b0, "R6", "wrap quiet");
        end
    endtask

    task automatic t_switch_on_load(input bit to_wrap);
        logic [W-1:0] g, x;
        div = 1;
        while (!(word_take === 1'b1 && bit_en === 1'b1)) step();
        @(negedge clk); loop_en = to_wrap;
        get_word(to_wrap, g, x);
        chkw(g, x, "R9", to_wrap ? "switch to wrap on load" : "switch to line on load");
    endtask

    initial begin
        t_reset();
        t_first_word();
        t_normal(3);
        seed = 7;
        t_normal(1);
        t_hold();
        t_wrap();
        t_rx_normal();
        seed = 11;
        t_switch_on_load(1'b1);
        t_switch_on_load(1'b0);
        t_reset();
        seed = 3;
        t_first_word();
        mon_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule